// File: doc/BRIEF.md
# Dual-Bank Flash Address Swap Remapper

This block sits between a CPU's flash request path and two groups of program flash banks, called group A and group B. It turns each CPU-side address into a physical bank address and a group select. With the feature turned on, one group is reached through a fixed executable code window and the other through a separate read/write data window. Setting the swap bit exchanges the two roles. Only the decode changes, so no data is copied, and software always runs from the same code-window addresses whichever group holds the live image.

The enable and swap settings come from a two-bit configuration word. That word is captured once, on the first clock after the synchronous reset is released, and stays fixed until the next reset. Requests tagged as non-volatile-memory commands (program, erase and similar sequences) skip the swap entirely and are decoded against the standard physical map. The two groups may differ in size. Only as many bytes of the code window as the smaller group holds are valid, so the unused upper part of the larger group can never be fetched as code. While the feature is on, the block also asserts a level that turns off the CPU's fast path to its local bank, so that execution timing is the same for both groups. Every response leaves a single output register, one cycle after its request.

Top module: `flash_swap_remap`

## Requirements
- R1: While reset is asserted, rsp_valid, rsp_err and fastpath_off are 0, and the captured configuration is "feature off, no swap".
- R2: On the first rising clock edge with rst low, cfg_word is captured (bit 0 = feature enable, bit 1 = swap select). Later changes to cfg_word have no effect on the mapping or on fastpath_off until the next reset.
- R3: fastpath_off equals the captured enable bit.
- R4: Every request with req_valid high gets exactly one response, with rsp_valid high, on the next clock edge. rsp_valid is low in any cycle that follows a cycle with no request.
- R5: A request with req_cmd = 1 ignores enable and swap. An address in [A_PHYS, A_PHYS+A_SIZE) gives rsp_grp = 1 (group A), and an address in [B_PHYS, B_PHYS+B_SIZE) gives rsp_grp = 2 (group B). In both cases rsp_addr equals req_addr.
- R6: With the feature on and req_cmd = 0, a code-window address CODE_BASE+off maps to the active group. That is group A (rsp_grp = 1, rsp_addr = A_PHYS+off) when swap = 0, and group B (rsp_grp = 2, rsp_addr = B_PHYS+off) when swap = 1.
- R7: With the feature on, a code-window offset of at least min(A_SIZE, B_SIZE) is an error, so the upper part of the larger group cannot be reached as code.
- R8: With the feature on, a data-window address DATA_BASE+off maps to the inactive group at that group's physical base plus off. It is valid for any off below that group's full size and an error at or above it.
- R9: With the feature off and req_cmd = 0, addresses in the physical ranges pass through unchanged, with the group select as in R5. Code-window and data-window addresses are errors.
- R10: An erroneous request, including any address outside every decoded range, yields rsp_err = 1, rsp_grp = 0 and rsp_addr = 0 for exactly its one response cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high system reset |
| cfg_word | input | 2 | Configuration word: bit 0 enable, bit 1 swap; captured after reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | 32 | CPU-side byte address |
| req_cmd | input | 1 | 1 = non-volatile-memory command access, 0 = fetch or read |
| rsp_valid | output | 1 | Response present (one cycle after the request) |
| rsp_addr | output | 32 | Physical bank address, 0 on error |
| rsp_grp | output | 2 | Bank group: 0 none, 1 group A, 2 group B |
| rsp_err | output | 1 | One-cycle decode error flag |
| fastpath_off | output | 1 | Disables the CPU's local-bank fast path while the feature is on |

## Verification
Two events can coincide: a run-time write to cfg_word and a code-window fetch issued in the same cycle. The bench drives both on one clock edge after the configuration has been captured. It passes if the fetch still lands in the originally selected group and fastpath_off does not move. A second overlap is a command access followed directly by a swapped code fetch. Here the bench checks, cycle by cycle, that each response takes its own map and that an error pulse in one cycle does not carry into the next response.

// File: rtl/flash_swap_pkg.sv
package flash_swap_pkg;

    parameter int ADDR_W = 32;

    typedef logic [ADDR_W-1:0] addr_t;

    typedef enum logic [1:0] {
        GRP_NONE = 2'd0,
        GRP_A    = 2'd1,
        GRP_B    = 2'd2
    } grp_e;

    typedef struct packed {
        logic en;
        logic swap;
    } swap_cfg_t;

    typedef struct packed {
        addr_t addr;
        grp_e  grp;
        logic  err;
    } map_res_t;

    localparam map_res_t MAP_ERR = '{addr: '0, grp: GRP_NONE, err: 1'b1};

    function automatic map_res_t map_ok(input addr_t a, input grp_e g);
        map_res_t r;
        r.addr = a;
        r.grp  = g;
        r.err  = 1'b0;
        return r;
    endfunction

    function automatic swap_cfg_t cfg_from_word(input logic [1:0] w);
        swap_cfg_t c;
        c.en   = w[0];
        c.swap = w[1];
        return c;
    endfunction

endpackage

// File: rtl/swap_cfg_latch.sv
module swap_cfg_latch
    import flash_swap_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] cfg_word,
    output swap_cfg_t  cfg
);

    logic loaded;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg    <= '{en: 1'b0, swap: 1'b0};
            loaded <= 1'b0;
        end else if (!loaded) begin
            cfg    <= cfg_from_word(cfg_word);
            loaded <= 1'b1;
        end
    end

    // R2: once captured, the configuration holds until the next reset
    assert_cfg_frozen_R2: assert property (@(posedge clk) disable iff (rst)
        (loaded && $past(loaded)) |-> $stable(cfg));

endmodule

// File: rtl/swap_win_hit.sv
module swap_win_hit
    import flash_swap_pkg::*;
#(
    parameter addr_t BASE = '0,
    parameter addr_t SPAN = addr_t'(1)
)(
    input  addr_t addr,
    output logic  hit
);

    addr_t off;

    always_comb begin
        off = addr - BASE;
        hit = (addr >= BASE) && (off < SPAN);
    end

endmodule

// File: rtl/swap_addr_decode.sv
module swap_addr_decode
    import flash_swap_pkg::*;
#(
    parameter addr_t CODE_BASE = 32'h8000_0000,
    parameter addr_t DATA_BASE = 32'h8800_0000,
    parameter addr_t WIN_SPAN  = 32'h0040_0000,
    parameter addr_t A_PHYS    = 32'hA000_0000,
    parameter addr_t A_SIZE    = 32'h0010_0000,
    parameter addr_t B_PHYS    = 32'hA010_0000,
    parameter addr_t B_SIZE    = 32'h0030_0000
)(
    input  addr_t     addr,
    input  logic      cmd,
    input  swap_cfg_t cfg,
    output map_res_t  res
);

    localparam int    NWIN     = 4;
    localparam int    W_CODE   = 0;
    localparam int    W_DATA   = 1;
    localparam int    W_PA     = 2;
    localparam int    W_PB     = 3;
    localparam addr_t CODE_LIM = (A_SIZE < B_SIZE) ? A_SIZE : B_SIZE;

    logic [NWIN-1:0] hit;

    for (genvar gi = 0; gi < NWIN; gi++) begin : g_win
        localparam addr_t WB = (gi == W_CODE) ? CODE_BASE :
                               (gi == W_DATA) ? DATA_BASE :
                               (gi == W_PA)   ? A_PHYS    : B_PHYS;
        localparam addr_t WS = (gi == W_CODE) ? WIN_SPAN :
                               (gi == W_DATA) ? WIN_SPAN :
                               (gi == W_PA)   ? A_SIZE   : B_SIZE;
        swap_win_hit #(.BASE(WB), .SPAN(WS)) i_hit (
            .addr (addr),
            .hit  (hit[gi])
        );
    end

    addr_t off_code;
    addr_t off_data;
    addr_t act_base;
    addr_t ina_base;
    addr_t ina_size;
    grp_e  act_grp;
    grp_e  ina_grp;

    always_comb begin
        off_code = addr - CODE_BASE;
        off_data = addr - DATA_BASE;
        act_base = cfg.swap ? B_PHYS : A_PHYS;
        act_grp  = cfg.swap ? GRP_B  : GRP_A;
        ina_base = cfg.swap ? A_PHYS : B_PHYS;
        ina_grp  = cfg.swap ? GRP_A  : GRP_B;
        ina_size = cfg.swap ? A_SIZE : B_SIZE;
        res      = MAP_ERR;
        if (cmd || !cfg.en) begin
            if (hit[W_PA])      res = map_ok(addr, GRP_A);
            else if (hit[W_PB]) res = map_ok(addr, GRP_B);
        end else begin
            if (hit[W_CODE] && (off_code < CODE_LIM))
                res = map_ok(act_base + off_code, act_grp);
            else if (hit[W_DATA] && (off_data < ina_size))
                res = map_ok(ina_base + off_data, ina_grp);
        end
    end

    // R7: a valid code-window fetch lands in the lower part of the active group
    always_comb begin
        if (!cmd && cfg.en && hit[W_CODE] && !res.err)
            assert_code_in_low_part_R7: assert ((res.addr - act_base) < CODE_LIM);
    end

endmodule

// File: rtl/swap_out_stage.sv
module swap_out_stage
    import flash_swap_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     in_valid,
    input  map_res_t in_res,
    output logic     out_valid,
    output map_res_t out_res
);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_res   <= '{addr: '0, grp: GRP_NONE, err: 1'b0};
        end else begin
            out_valid <= in_valid;
            out_res   <= in_valid ? in_res : '{addr: '0, grp: GRP_NONE, err: 1'b0};
        end
    end

    // R4: fixed one-cycle latency
    assert_resp_follows_req_R4: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    assert_no_spurious_resp_R4: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

endmodule

// File: rtl/flash_swap_remap.sv
module flash_swap_remap
    import flash_swap_pkg::*;
#(
    parameter addr_t CODE_BASE = 32'h8000_0000,
    parameter addr_t DATA_BASE = 32'h8800_0000,
    parameter addr_t WIN_SPAN  = 32'h0040_0000,
    parameter addr_t A_PHYS    = 32'hA000_0000,
    parameter addr_t A_SIZE    = 32'h0010_0000,
    parameter addr_t B_PHYS    = 32'hA010_0000,
    parameter addr_t B_SIZE    = 32'h0030_0000
)(
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        cfg_word,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_cmd,
    output logic              rsp_valid,
    output logic [ADDR_W-1:0] rsp_addr,
    output logic [1:0]        rsp_grp,
    output logic              rsp_err,
    output logic              fastpath_off
);

    swap_cfg_t cfg;
    map_res_t  dec_res;
    map_res_t  reg_res;

    swap_cfg_latch i_cfg (
        .clk      (clk),
        .rst      (rst),
        .cfg_word (cfg_word),
        .cfg      (cfg)
    );

    swap_addr_decode #(
        .CODE_BASE (CODE_BASE),
        .DATA_BASE (DATA_BASE),
        .WIN_SPAN  (WIN_SPAN),
        .A_PHYS    (A_PHYS),
        .A_SIZE    (A_SIZE),
        .B_PHYS    (B_PHYS),
        .B_SIZE    (B_SIZE)
    ) i_dec (
        .addr (req_addr),
        .cmd  (req_cmd),
        .cfg  (cfg),
        .res  (dec_res)
    );

    swap_out_stage i_out (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (req_valid),
        .in_res    (dec_res),
        .out_valid (rsp_valid),
        .out_res   (reg_res)
    );

    assign rsp_addr     = reg_res.addr;
    assign rsp_grp      = reg_res.grp;
    assign rsp_err      = reg_res.err;
    assign fastpath_off = cfg.en;

    // R5: a successful command access returns its own address unchanged
    assert_cmd_bypass_R5: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_cmd) |=> (rsp_err || (rsp_addr == $past(req_addr))));

    // R10: an error carries no group and no address
    assert_err_clean_R10: assert property (@(posedge clk) disable iff (rst)
        rsp_err |-> (rsp_valid && rsp_grp == 2'd0 && rsp_addr == '0));

    // R10: a successful response always names a group
    assert_ok_has_group_R10: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_err) |-> (rsp_grp == 2'd1 || rsp_grp == 2'd2));

endmodule

// File: tb/test_flash_swap_remap.sv
`timescale 1ns/1ps
module test_flash_swap_remap;

    localparam logic [31:0] CB = 32'h8000_0000;
    localparam logic [31:0] DB = 32'h8800_0000;
    localparam logic [31:0] PA = 32'hA000_0000;
    localparam logic [31:0] PB = 32'hA010_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  cfg_word = 2'b00;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_cmd = 1'b0;
    logic        rsp_valid;
    logic [31:0] rsp_addr;
    logic [1:0]  rsp_grp;
    logic        rsp_err;
    logic        fastpath_off;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    flash_swap_remap i_flash_swap_remap (
        .clk          (clk),
        .rst          (rst),
        .cfg_word     (cfg_word),
        .req_valid    (req_valid),
        .req_addr     (req_addr),
        .req_cmd      (req_cmd),
        .rsp_valid    (rsp_valid),
        .rsp_addr     (rsp_addr),
        .rsp_grp      (rsp_grp),
        .rsp_err      (rsp_err),
        .fastpath_off (fastpath_off)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // reset with a configuration; the word is captured on the first edge after release
    task automatic do_reset(input logic [1:0] w);
        @(negedge clk);
        rst = 1'b1; req_valid = 1'b0; cfg_word = w;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    // one request, response checked one clock later
    task automatic send(input bit cmd, input logic [31:0] a, input logic [1:0] eg,
                        input logic [31:0] ea, input bit ee, input string tag);
        req_valid = 1'b1; req_cmd = cmd; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        chk(rsp_valid == 1'b1, {tag, " valid"}, 64'(rsp_valid), 64'd1);
        chk(rsp_err == ee, {tag, " err"}, 64'(rsp_err), 64'(ee));
        chk(rsp_grp == eg, {tag, " grp"}, 64'(rsp_grp), 64'(eg));
        chk(rsp_addr == ea, {tag, " addr"}, 64'(rsp_addr), 64'(ea));
    endtask

    task automatic t_reset_state;
        @(negedge clk);
        rst = 1'b1; cfg_word = 2'b11; req_valid = 1'b1; req_addr = CB;
        repeat (2) @(negedge clk);
        chk(rsp_valid == 0, "R1 valid in reset", 64'(rsp_valid), 0);
        chk(rsp_err == 0, "R1 err in reset", 64'(rsp_err), 0);
        chk(fastpath_off == 0, "R1 fastpath in reset", 64'(fastpath_off), 0);
        req_valid = 1'b0;
    endtask

    task automatic t_cmd_bypass;
        do_reset(2'b11);
        send(1, PA + 32'h1234, 2'd1, PA + 32'h1234, 0, "R5 cmd group A");
        send(1, PB + 32'h2F_FFF0, 2'd2, PB + 32'h2F_FFF0, 0, "R5 cmd group B");
        send(1, CB, 2'd0, 32'h0, 1, "R10 cmd in code window");
    endtask

    task automatic t_swap0;
        do_reset(2'b01);
        chk(fastpath_off == 1, "R3 fastpath on", 64'(fastpath_off), 1);
        send(0, CB + 32'h100, 2'd1, PA + 32'h100, 0, "R6 code to A");
        send(0, CB + 32'hF_FFFC, 2'd1, PA + 32'hF_FFFC, 0, "R7 last valid code word");
        send(0, CB + 32'h10_0000, 2'd0, 32'h0, 1, "R7 code past limit");
        send(0, DB + 32'h2F_0000, 2'd2, PB + 32'h2F_0000, 0, "R8 data to B");
        send(0, DB + 32'h30_0000, 2'd0, 32'h0, 1, "R8 data past B");
        send(0, PA, 2'd0, 32'h0, 1, "R10 physical read while on");
    endtask

    task automatic t_swap1;
        do_reset(2'b11);
        send(0, CB + 32'h40, 2'd2, PB + 32'h40, 0, "R6 code to B");
        send(0, CB + 32'h20_0000, 2'd0, 32'h0, 1, "R7 upper part of B");
        send(0, DB + 32'h8, 2'd1, PA + 32'h8, 0, "R8 data to A");
        send(0, DB + 32'h10_0000, 2'd0, 32'h0, 1, "R8 data past A");
    endtask

    task automatic t_disabled;
        do_reset(2'b10);
        chk(fastpath_off == 0, "R3 fastpath off", 64'(fastpath_off), 0);
        send(0, PB + 32'h4, 2'd2, PB + 32'h4, 0, "R9 pass through B");
        send(0, PA + 32'h10, 2'd1, PA + 32'h10, 0, "R9 pass through A");
        send(0, CB, 2'd0, 32'h0, 1, "R9 code window off");
        send(0, DB, 2'd0, 32'h0, 1, "R9 data window off");
    endtask

    // run-time config write in the same cycle as a fetch
    task automatic t_cfg_hold;
        do_reset(2'b01);
        cfg_word = 2'b10;
        send(0, CB + 32'h20, 2'd1, PA + 32'h20, 0, "R2 write with fetch");
        repeat (3) @(negedge clk);
        chk(fastpath_off == 1, "R2 fastpath held", 64'(fastpath_off), 1);
        send(0, CB + 32'h24, 2'd1, PA + 32'h24, 0, "R2 mapping held");
        do_reset(2'b11);
        send(0, CB + 32'h24, 2'd2, PB + 32'h24, 0, "R2 new map after reset");
    endtask

    // back-to-back: command, error, good fetch, idle
    task automatic t_stream;
        do_reset(2'b11);
        req_valid = 1; req_cmd = 1; req_addr = PA + 32'h8;
        @(negedge clk);
        chk(rsp_valid && !rsp_err && rsp_grp == 2'd1 && rsp_addr == PA + 32'h8,
            "R5 cmd in stream", 64'(rsp_addr), 64'(PA + 32'h8));
        req_cmd = 0; req_addr = CB + 32'h30_0000;
        @(negedge clk);
        chk(rsp_valid && rsp_err, "R10 error in stream", 64'(rsp_err), 1);
        req_addr = CB + 32'h80;
        @(negedge clk);
        chk(rsp_valid && !rsp_err, "R10 error lasts one cycle", 64'(rsp_err), 0);
        chk(rsp_grp == 2'd2 && rsp_addr == PB + 32'h80, "R6 fetch after error", 64'(rsp_addr), 64'(PB + 32'h80));
        req_valid = 0;
        @(negedge clk);
        chk(rsp_valid == 0, "R4 idle gives no response", 64'(rsp_valid), 0);
        chk(rsp_err == 0, "R4 idle no error", 64'(rsp_err), 0);
    endtask

    initial begin
        t_reset_state();
        t_cmd_bypass();
        t_swap0();
        t_swap1();
        t_disabled();
        t_cfg_hold();
        t_stream();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule